// File: doc/BRIEF.md
# Boundary-Scan Data Path with Output-Bus Disable Cell

This block is the data side of a test access port. A separate TAP state machine supplies decoded state strobes, and an instruction shift register supplies its parallel contents. From these the block keeps the active test mode, captures the device pins into a long scan chain, shifts the chain or a single bypass bit between the serial input and the serial output, and copies the chain into a parallel preload register that can drive the device's output pins.

One cell of the preload register, at the top of the chain, acts as an output-bus enable while the external-drive mode is active. A dedicated high-impedance sampling mode keeps the output bus disabled until the next instruction takes effect. Reserved instruction codes behave like bypass and leave the output bus in normal use.

The chain holds `BSR_LEN` cells. Cell 0 lies next to the serial output. On each rising test clock in the shift state, every cell takes the value of its upper neighbour, and the serial input enters the top cell. The serial output is re-timed on the falling test clock.

Top module: `bscan_path`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `pins_o` has only bit `OE_BIT` (108) set, `out_en_o` is 1, `ext_mode_o` is 0 and the bypass bit is the serial path.
- R2: `ir_i` is taken into the active mode only on a rising `tck_i` with `update_ir_i` high. A changed `ir_i` without that strobe has no effect on `out_en_o` or `ext_mode_o`.
- R3: Code 3'b010 (high-Z sample) drives `out_en_o` to 0 from the Update-IR edge until the next Update-IR edge, including across capture, shift and update of the chain. The chain is the serial path.
- R4: With code 3'b100 (sample/preload), a rising `tck_i` with `capture_dr_i` loads `pins_i` into the chain. The following shift presents bit 0 first on `tdo_o`.
- R5: In the shift state, each rising `tck_i` moves the chain one cell toward bit 0 and loads `tdi_i` into bit `BSR_LEN-1`. Shifting in new data and shifting out captured data happen in the same pass.
- R6: `tdo_o` changes only on the falling `tck_i`. Just after a rising shift edge it still shows the bit from before that edge.
- R7: A rising `tck_i` with `update_dr_i`, in a mode that selects the chain, copies the chain into `pins_o`. `pins_o` is otherwise held.
- R8: Code 3'b111 and the reserved codes 3'b001, 3'b011, 3'b101 and 3'b110 select the one-bit bypass path. Capture loads 0 into it, so `tdo_o` shows 0 and then `tdi_i` delayed by one shift. `update_dr_i` leaves `pins_o` unchanged, `out_en_o` is 1 and `ext_mode_o` is 0.
- R9: Code 3'b000 (external drive) sets `ext_mode_o` to 1 and makes `out_en_o` equal `pins_o[108]`. That bit can be loaded under external drive or under sample/preload.
- R10: A rising `tck_i` with `tlr_i` sets `pins_o[108]` to 1 and returns the mode to bypass. All other preload bits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tlr_i | input | 1 | TAP is in Test-Logic-Reset |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| update_ir_i | input | 1 | TAP is in Update-IR |
| tdi_i | input | 1 | Serial test data in |
| ir_i | input | IR_W | Instruction register contents |
| pins_i | input | BSR_LEN | Parallel pin values for capture |
| tdo_o | output | 1 | Serial test data out, falling-edge timed |
| byp_o | output | 1 | Bypass bit |
| pins_o | output | BSR_LEN | Preload register contents |
| ext_mode_o | output | 1 | Preload register drives the output pins |
| out_en_o | output | 1 | Output-bus driver enable |

## Verification
The hardest case to reach is the enable cell under external drive after Test-Logic-Reset. A 0 must first be latched into bit 108, which takes a full 109-bit shift followed by an update. Only then can the reset be seen to force that one bit back to 1 while every other preload bit keeps its value. The stimulus loads distinct patterns with bit 108 cleared under both sample/preload and external drive, and it reads the whole preload vector before and after the reset strobe. Every shifted-out stream is collected at the falling edge, so that falling-edge timing and concurrent shift-in are both checked against the captured pattern.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] IR_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] IR_HIZ    = 3'b010;
  localparam logic [IR_W-1:0] IR_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] IR_BYPASS = 3'b111;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SAMPLE = 2'd1,
    MODE_HIZ    = 2'd2,
    MODE_EXTEST = 2'd3
  } bs_mode_e;

  function automatic bs_mode_e decode_ir(logic [IR_W-1:0] ir);
    case (ir)
      IR_EXTEST: return MODE_EXTEST;
      IR_HIZ:    return MODE_HIZ;
      IR_SAMPLE: return MODE_SAMPLE;
      default:   return MODE_BYPASS; // bypass code and reserved codes
    endcase
  endfunction
endpackage

// File: rtl/bscan_mode.sv
module bscan_mode
  import bscan_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tlr_i,
  input  logic            update_ir_i,
  input  logic [IR_W-1:0] ir_i,
  output bs_mode_e        mode_o
);
  bs_mode_e mode_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= MODE_BYPASS;
    else if (tlr_i)       mode_q <= MODE_BYPASS;
    else if (update_ir_i) mode_q <= decode_ir(ir_i);
  end

  assign mode_o = mode_q;

  // R2
  mode_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!update_ir_i && !tlr_i) |=> $stable(mode_q));
  // R10
  tlr_mode_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (mode_q == MODE_BYPASS));
endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr #(
  parameter int BSR_LEN = 109,
  parameter int OE_BIT  = 108
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tlr_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               so_o,
  output logic [BSR_LEN-1:0] upd_o
);
  logic [BSR_LEN-1:0] sh_q;
  logic [BSR_LEN-1:0] upd_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (capture_i) sh_q <= pins_i;
    else if (shift_i)   sh_q <= {tdi_i, sh_q[BSR_LEN-1:1]};
  end

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_upd
    if (i == OE_BIT) begin : g_oe
      // output-bus enable cell: set on reset and in Test-Logic-Reset
      always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni)       upd_q[i] <= 1'b1;
        else if (tlr_i)    upd_q[i] <= 1'b1;
        else if (update_i) upd_q[i] <= sh_q[i];
      end
    end else begin : g_data
      always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni)       upd_q[i] <= 1'b0;
        else if (update_i) upd_q[i] <= sh_q[i];
      end
    end
  end

  assign so_o  = sh_q[0];
  assign upd_o = upd_q;

  // R5
  shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (sh_q == {$past(tdi_i), $past(sh_q[BSR_LEN-1:1])}));
  // R7
  upd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!update_i && !tlr_i) |=> $stable(upd_q));
  // R10
  tlr_oe_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> upd_q[OE_BIT]);
endmodule

// File: rtl/bscan_bypass.sv
module bscan_bypass (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic byp_o
);
  logic byp_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        byp_q <= 1'b0;
    else if (capture_i) byp_q <= 1'b0;
    else if (shift_i)   byp_q <= tdi_i;
  end

  assign byp_o = byp_q;

  // R8
  byp_cap_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> !byp_q);
endmodule

// File: rtl/bscan_path.sv
module bscan_path
  import bscan_pkg::*;
#(
  parameter int BSR_LEN = 109,
  parameter int OE_BIT  = 108
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tlr_i,
  input  logic               capture_dr_i,
  input  logic               shift_dr_i,
  input  logic               update_dr_i,
  input  logic               update_ir_i,
  input  logic               tdi_i,
  input  logic [IR_W-1:0]    ir_i,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               tdo_o,
  output logic               byp_o,
  output logic [BSR_LEN-1:0] pins_o,
  output logic               ext_mode_o,
  output logic               out_en_o
);
  bs_mode_e mode;
  logic     sel_bsr;
  logic     bsr_so;
  logic     tdo_q;

  bscan_mode i_mode (
    .tck_i, .rst_ni, .tlr_i, .update_ir_i, .ir_i,
    .mode_o (mode)
  );

  assign sel_bsr = (mode != MODE_BYPASS);

  bscan_bsr #(.BSR_LEN(BSR_LEN), .OE_BIT(OE_BIT)) i_bsr (
    .tck_i, .rst_ni, .tlr_i,
    .capture_i (capture_dr_i && sel_bsr),
    .shift_i   (shift_dr_i && sel_bsr),
    .update_i  (update_dr_i && sel_bsr),
    .tdi_i,
    .pins_i,
    .so_o      (bsr_so),
    .upd_o     (pins_o)
  );

  bscan_bypass i_byp (
    .tck_i, .rst_ni,
    .capture_i (capture_dr_i && !sel_bsr),
    .shift_i   (shift_dr_i && !sel_bsr),
    .tdi_i,
    .byp_o
  );

  // serial output re-timed on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else         tdo_q <= sel_bsr ? bsr_so : byp_o;
  end

  assign tdo_o      = tdo_q;
  assign ext_mode_o = (mode == MODE_EXTEST);
  assign out_en_o   = (mode == MODE_HIZ)    ? 1'b0 :
                      (mode == MODE_EXTEST) ? pins_o[OE_BIT] : 1'b1;

  // R3
  hiz_update_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_ir_i && !tlr_i && ir_i == IR_HIZ) |=> !out_en_o);
  // R9
  extest_enter_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_ir_i && !tlr_i && ir_i == IR_EXTEST) |=> (ext_mode_o && out_en_o == pins_o[OE_BIT]));
endmodule

// File: tb/test_bscan_path.sv
`timescale 1ns/100ps
module test_bscan_path;
  localparam int L  = 109;
  localparam int OE = 108;

  logic tck = 1'b0, rst_n = 1'b0;
  logic tlr = 0, cap = 0, sh = 0, upd = 0, uir = 0, tdi = 0;
  logic [2:0]   ir = 3'b111;
  logic [L-1:0] pins = '0;
  logic tdo, byp, ext, oen;
  logic [L-1:0] pout;

  always #2 tck = ~tck;

  bscan_path i_bscan_path (
    .tck_i(tck), .rst_ni(rst_n), .tlr_i(tlr), .capture_dr_i(cap), .shift_dr_i(sh),
    .update_dr_i(upd), .update_ir_i(uir), .tdi_i(tdi), .ir_i(ir), .pins_i(pins),
    .tdo_o(tdo), .byp_o(byp), .pins_o(pout), .ext_mode_o(ext), .out_en_o(oen)
  );

  typedef enum int {K_PINS, K_OEN, K_EXT, K_TDO, K_GOT} kind_e;
  typedef struct { string req; kind_e kind; logic [L-1:0] exp; } item_t;
  item_t q[$];
  event chk_ev;
  int n_chk = 0, n_bad = 0;
  logic [L-1:0] got_v;
  bit done = 0;

  task automatic expect_item(string req, kind_e k, logic [L-1:0] e);
    item_t it;
    it.req = req; it.kind = k; it.exp = e;
    q.push_back(it);
    -> chk_ev;
    #0.2;
  endtask

  // monitor: pops expectations and compares with the design's outputs
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [L-1:0] act;
      it = q.pop_front();
      case (it.kind)
        K_PINS:  act = pout;
        K_OEN:   act = L'(oen);
        K_EXT:   act = L'(ext);
        K_TDO:   act = L'(tdo);
        default: act = got_v;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: act=%h exp=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge tck); #1;
  endtask
  task automatic load_ir(logic [2:0] c);
    ir = c; uir = 1; tick(); uir = 0;
  endtask
  task automatic capture(logic [L-1:0] p);
    pins = p; cap = 1; tick(); cap = 0;
  endtask
  task automatic update_dr();
    upd = 1; tick(); upd = 0;
  endtask
  // full-length shift; collects tdo at each falling edge into got_v
  task automatic shift_vec(logic [L-1:0] din, bit chk6);
    sh = 1;
    for (int i = 0; i < L; i++) begin
      tdi = din[i];
      @(negedge tck); #0.5;
      got_v[i] = tdo;
      tick();
      if (chk6 && i == 0) expect_item("R6 tdo held after rising edge", K_TDO, L'(got_v[0]));
    end
    sh = 0;
  endtask

  logic [L-1:0] pa = {13'h0F0F, 32'h12345678, 32'h9ABCDEF0, 32'h0BADF00D};
  logic [L-1:0] pb = {13'h0ACE, 32'hDEADBEEF, 32'h13579BDF, 32'h2468ACE0};
  logic [L-1:0] pc = {13'h1234, 32'hCAFEF00D, 32'h55AA33CC, 32'h0F1E2D3C};
  logic [L-1:0] pd = {13'h0777, 32'h89ABCDEF, 32'h01234567, 32'hFEDCBA98};
  logic [L-1:0] oe_only = L'(1) << OE;

  initial begin
    #10;
    expect_item("R1 pins_o in reset", K_PINS, oe_only);
    expect_item("R1 out_en in reset", K_OEN, L'(1));
    expect_item("R1 ext_mode in reset", K_EXT, L'(0));
    #0.8; rst_n = 1;
    tick();
    expect_item("R1 pins_o after reset", K_PINS, oe_only);

    // R2: instruction change without Update-IR has no effect
    ir = 3'b010; tick(); tick();
    expect_item("R2 out_en unchanged without update_ir", K_OEN, L'(1));

    // R3: high-Z sample mode
    load_ir(3'b010);
    expect_item("R3 out_en low in hiz mode", K_OEN, L'(0));
    capture(pa);
    shift_vec(pc, 0);
    expect_item("R3 chain is serial path in hiz", K_GOT, pa);
    update_dr();
    expect_item("R3 out_en still low after update_dr", K_OEN, L'(0));
    expect_item("R7 update in hiz mode", K_PINS, pc);

    // R4/R5/R6/R7: sample/preload
    load_ir(3'b100);
    expect_item("R3 out_en back high after new update_ir", K_OEN, L'(1));
    capture(pa);
    shift_vec(pb, 1);
    expect_item("R4 captured pins shifted out bit0 first", K_GOT, pa);
    expect_item("R7 pins_o held before update_dr", K_PINS, pc);
    update_dr();
    expect_item("R5 shifted-in data reaches preload", K_PINS, pb);
    capture(pd);
    shift_vec(pc, 0);
    expect_item("R5 second pass shifts out capture", K_GOT, pd);
    expect_item("R7 pins_o held without update_dr", K_PINS, pb);

    // R9: external drive; pb[108]=0 loaded under sample/preload
    load_ir(3'b000);
    expect_item("R9 ext_mode set", K_EXT, L'(1));
    expect_item("R9 out_en follows cleared cell", K_OEN, L'(0));
    capture(pa);
    shift_vec(pc, 0);
    update_dr();
    expect_item("R9 out_en follows set cell", K_OEN, L'(1));
    capture(pa);
    shift_vec(pd, 0);
    update_dr();
    expect_item("R9 out_en cleared under extest load", K_OEN, L'(0));

    // R10: Test-Logic-Reset forces only the enable cell
    tlr = 1; tick(); tlr = 0;
    expect_item("R10 only enable cell forced", K_PINS, pd | oe_only);
    expect_item("R10 mode back to bypass", K_EXT, L'(0));
    expect_item("R10 out_en high", K_OEN, L'(1));

    // R8: bypass and a reserved code
    foreach (ir[j]) begin end
    load_ir(3'b111);
    capture(pa);
    shift_vec(pb, 0);
    expect_item("R8 bypass: 0 then tdi delayed", K_GOT, {pb[L-2:0], 1'b0});
    update_dr();
    expect_item("R8 update_dr ignored in bypass", K_PINS, pd | oe_only);
    load_ir(3'b101);
    expect_item("R8 reserved code out_en high", K_OEN, L'(1));
    expect_item("R8 reserved code ext_mode low", K_EXT, L'(0));
    capture(pa);
    shift_vec(pc, 0);
    expect_item("R8 reserved code uses bypass bit", K_GOT, {pc[L-2:0], 1'b0});
    update_dr();
    expect_item("R8 reserved code keeps pins_o", K_PINS, pd | oe_only);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule